// File: doc/BRIEF.md
# Cut-Through Transmit Packet FIFO

This block buffers outgoing asynchronous packets between a host-side writer and a link-side reader. The writer pushes 32-bit words, and each word carries a flag that marks the final word of its packet. The reader is offered a packet once enough of it is buffered. That point is either a programmable byte threshold or the moment the packet's final word is stored, whichever comes first. A low threshold lets the link start earlier. The price is the risk that the reader runs dry partway through the packet.

A run-dry partway through a packet is an underrun. The block reports it with a one-cycle error pulse. It rewinds its read position to the first word of the packet, which is still held in the buffer. From then on it works in store-and-forward mode: the packet is offered again only once its final word is stored. This mode lasts until the next active-low reset. Store-and-forward also applies whenever the enhancement-enable input or the retry-enable input is low, and whenever the threshold code selects the 2K setting.

The buffer holds 512 words (2048 bytes). Thresholds are compared in bytes, at four bytes per stored word.

Top module: `tx_cut_fifo`

## Requirements
- R1: After reset, wr_ready is 1, rd_valid is 0 and rd_err is 0.
- R2: With cfg_enh_en=1, cfg_retry_en=1 and cfg_thresh=2'b01, a packet is offered (rd_valid=1) once 1728 bytes (432 words) of it are stored, and not before.
- R3: With cfg_thresh=2'b10 the start point is 1024 bytes (256 words). With cfg_thresh=2'b11 it is 512 bytes (128 words).
- R4: With cfg_thresh=2'b00 a packet is never offered before its final word (wr_last=1) is stored.
- R5: A packet whose final word is stored is offered even when it is shorter than the selected threshold.
- R6: If rd_ready=1 while a packet is being offered and no next word of it is stored, rd_err is 1 for exactly one cycle and rd_valid then drops.
- R7: After an underrun, the same packet is offered again from its first word, only once its final word is stored. Every later packet also waits for its final word, whatever the threshold. Only rst_n=0 clears this mode.
- R8: With cfg_retry_en=0 the block works store-and-forward, whatever cfg_thresh holds.
- R9: With cfg_enh_en=0 the block works store-and-forward, whatever cfg_thresh holds.
- R10: Words are read out in write order, with rd_last=1 on each packet's final word. A packet's words occupy space until its final word is read. wr_ready is 0 exactly when 512 words are held, and no word is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; also clears store-and-forward lock |
| cfg_thresh | input | 2 | Start threshold code: 00 2K, 01 1728 B, 10 1024 B, 11 512 B |
| cfg_enh_en | input | 1 | Enables threshold use |
| cfg_retry_en | input | 1 | Enables threshold use; 0 forces store-and-forward |
| wr_valid | input | 1 | Write word valid |
| wr_data | input | 32 | Write word |
| wr_last | input | 1 | Word is the last of its packet |
| wr_ready | output | 1 | Space for one more word |
| rd_valid | output | 1 | Read word valid |
| rd_data | output | 32 | Read word |
| rd_last | output | 1 | Read word is the last of its packet |
| rd_ready | input | 1 | Reader takes the word (or demands one) |
| rd_err | output | 1 | Underrun pulse |

## Verification
The start decision is probed with a packet held one word below each threshold and then one word at it. This separates the four threshold codes and catches off-by-one comparisons. Packets are also held far above the threshold with no final word, with cut-through made illegal through the 00 code, through either enable, and through the lock left by an underrun. This shows the gating paths act independently of each other. A short complete packet separates start-on-final-word from start-on-threshold. A forced underrun followed by a full replay, and a fill to exactly 512 words across two packets, check the rewind and the space accounting.

// File: rtl/tx_cut_fifo.sv
module tx_cut_fifo #(
  parameter int DEPTH         = 512,
  parameter int THR_HI_BYTES  = 1728,
  parameter int THR_MID_BYTES = 1024,
  parameter int THR_LO_BYTES  = 512
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  cfg_thresh,
  input  logic        cfg_enh_en,
  input  logic        cfg_retry_en,
  input  logic        wr_valid,
  input  logic [31:0] wr_data,
  input  logic        wr_last,
  output logic        wr_ready,
  output logic        rd_valid,
  output logic [31:0] rd_data,
  output logic        rd_last,
  input  logic        rd_ready,
  output logic        rd_err
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL    = (AW+1)'(DEPTH);
  localparam logic [AW:0] THR_HI  = (AW+1)'(THR_HI_BYTES / 4);
  localparam logic [AW:0] THR_MID = (AW+1)'(THR_MID_BYTES / 4);
  localparam logic [AW:0] THR_LO  = (AW+1)'(THR_LO_BYTES / 4);

  logic [32:0] mem [DEPTH];
  logic [AW:0] wptr, rptr, sptr, eop_cnt, used, thr_words;
  logic        sending, sf_lock;
  logic        wr_fire, rd_fire, empty, cut_ok, start, pkt_done;

  assign used     = wptr - sptr;
  assign wr_ready = used < FULL;
  assign wr_fire  = wr_valid & wr_ready;
  assign empty    = rptr == wptr;
  assign rd_valid = sending & ~empty;
  assign {rd_last, rd_data} = mem[rptr[AW-1:0]];
  assign rd_fire  = rd_valid & rd_ready;
  assign rd_err   = sending & rd_ready & empty;
  assign pkt_done = rd_fire & rd_last;
  assign cut_ok   = cfg_enh_en & cfg_retry_en & ~sf_lock & (cfg_thresh != 2'b00);

  always_comb begin
    case (cfg_thresh)
      2'b01:   thr_words = THR_HI;
      2'b10:   thr_words = THR_MID;
      2'b11:   thr_words = THR_LO;
      default: thr_words = FULL;
    endcase
  end

  assign start = ~sending & ((eop_cnt != '0) | (cut_ok & (used >= thr_words)));

  always_ff @(posedge clk) begin
    if (wr_fire) mem[wptr[AW-1:0]] <= {wr_last, wr_data};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr    <= '0;
      rptr    <= '0;
      sptr    <= '0;
      eop_cnt <= '0;
      sending <= 1'b0;
      sf_lock <= 1'b0;
    end else begin
      if (wr_fire) wptr <= wptr + 1'b1;
      eop_cnt <= eop_cnt + (AW+1)'(wr_fire & wr_last) - (AW+1)'(pkt_done);
      if (rd_err) begin
        rptr    <= sptr;
        sending <= 1'b0;
        sf_lock <= 1'b1;
      end else if (rd_fire) begin
        rptr <= rptr + 1'b1;
        if (rd_last) begin
          sptr    <= rptr + 1'b1;
          sending <= 1'b0;
        end
      end else if (start) begin
        sending <= 1'b1;
      end
    end
  end

  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err |=> !rd_err);  // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wptr == $past(wptr)));  // R10
  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    sf_lock |=> sf_lock);  // R7
  AST_REWIND: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err |=> (rptr == $past(sptr)) && !rd_valid);  // R7
  AST_SF_WAIT_EOP: assert property (@(posedge clk) disable iff (!rst_n)
    (!sending && eop_cnt == '0 &&
     (sf_lock || !cfg_retry_en || !cfg_enh_en || cfg_thresh == 2'b00)) |=> !rd_valid);  // R4
endmodule

// File: tb/sim_tx_cut_fifo.sv
module sim_tx_cut_fifo;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_thresh = 2'b01;
  logic        cfg_enh_en = 1'b1, cfg_retry_en = 1'b1;
  logic        wr_valid = 1'b0, wr_last = 1'b0, rd_ready = 1'b0;
  logic [31:0] wr_data = '0;
  logic        wr_ready, rd_valid, rd_last, rd_err;
  logic [31:0] rd_data;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  tx_cut_fifo u0 (.clk, .rst_n, .cfg_thresh, .cfg_enh_en, .cfg_retry_en,
    .wr_valid, .wr_data, .wr_last, .wr_ready, .rd_valid, .rd_data, .rd_last,
    .rd_ready, .rd_err);

  function automatic logic [31:0] wv(input int tag, input int idx);
    return {tag[7:0], 8'h00, idx[15:0]};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] thr, input logic enh, input logic rty);
    @(negedge clk);
    rst_n = 1'b0; wr_valid = 1'b0; rd_ready = 1'b0;
    cfg_thresh = thr; cfg_enh_en = enh; cfg_retry_en = rty;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic push_run(input int tag, input int first, input int n, input logic fin);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_valid = 1'b1; wr_data = wv(tag, first + i); wr_last = fin && (i == n - 1);
      while (!wr_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    wr_valid = 1'b0; wr_last = 1'b0;
  endtask

  task automatic pop_run(input string req, input int tag, input int first, input int n, input logic fin);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      while (!rd_valid) begin rd_ready = 1'b0; @(negedge clk); end
      rd_ready = 1'b1;
      chk(req, {32'd0, rd_data}, {32'd0, wv(tag, first + i)});
      if (i == n - 1) chk(req, 64'(rd_last), 64'(fin));
      @(posedge clk);
    end
    @(negedge clk);
    rd_ready = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    do_reset(2'b01, 1'b1, 1'b1);
    chk("R1 wr_ready", 64'(wr_ready), 64'd1);
    chk("R1 rd_valid", 64'(rd_valid), 64'd0);
    chk("R1 rd_err", 64'(rd_err), 64'd0);
  endtask

  task automatic t_thresh(input string req, input logic [1:0] code, input int words);
    do_reset(code, 1'b1, 1'b1);
    push_run(1, 0, words - 1, 1'b0);
    wait_cyc(3);
    chk({req, " below threshold"}, 64'(rd_valid), 64'd0);
    push_run(1, words - 1, 1, 1'b0);
    wait_cyc(2);
    chk({req, " at threshold"}, 64'(rd_valid), 64'd1);
    push_run(1, words, 4, 1'b1);
    pop_run({req, " R10 data"}, 1, 0, words + 4, 1'b1);
  endtask

  task automatic t_no_cut(input string req, input logic [1:0] code, input logic enh, input logic rty);
    do_reset(code, enh, rty);
    push_run(2, 0, 480, 1'b0);
    wait_cyc(3);
    chk({req, " no start before last"}, 64'(rd_valid), 64'd0);
    push_run(2, 480, 1, 1'b1);
    wait_cyc(2);
    chk({req, " start after last"}, 64'(rd_valid), 64'd1);
    pop_run({req, " data"}, 2, 0, 481, 1'b1);
  endtask

  task automatic t_short;
    do_reset(2'b11, 1'b1, 1'b1);
    push_run(3, 0, 10, 1'b1);
    wait_cyc(2);
    chk("R5 short packet start", 64'(rd_valid), 64'd1);
    pop_run("R5 short data", 3, 0, 10, 1'b1);
  endtask

  task automatic t_underrun;
    do_reset(2'b11, 1'b1, 1'b1);
    push_run(4, 0, 128, 1'b0);
    pop_run("R6 pre-underrun data", 4, 0, 127, 1'b0);
    @(negedge clk);
    rd_ready = 1'b1;
    chk("R6 last buffered word", {32'd0, rd_data}, {32'd0, wv(4, 127)});
    @(posedge clk);
    @(negedge clk);
    chk("R6 rd_err raised", 64'(rd_err), 64'd1);
    chk("R6 rd_valid low at underrun", 64'(rd_valid), 64'd0);
    @(negedge clk);
    rd_ready = 1'b0;
    chk("R6 rd_err one cycle", 64'(rd_err), 64'd0);
    push_run(4, 128, 20, 1'b0);
    wait_cyc(3);
    chk("R7 retry waits for last", 64'(rd_valid), 64'd0);
    push_run(4, 148, 1, 1'b1);
    wait_cyc(2);
    chk("R7 retry starts", 64'(rd_valid), 64'd1);
    pop_run("R7 replay from start", 4, 0, 149, 1'b1);
    push_run(5, 0, 200, 1'b0);
    wait_cyc(3);
    chk("R7 lock on later packet", 64'(rd_valid), 64'd0);
    push_run(5, 200, 1, 1'b1);
    pop_run("R7 later packet data", 5, 0, 201, 1'b1);
    do_reset(2'b11, 1'b1, 1'b1);
    push_run(6, 0, 128, 1'b0);
    wait_cyc(2);
    chk("R7 reset clears lock", 64'(rd_valid), 64'd1);
  endtask

  task automatic t_full;
    do_reset(2'b00, 1'b1, 1'b1);
    push_run(7, 0, 300, 1'b1);
    push_run(8, 0, 211, 1'b0);
    chk("R10 ready at 511", 64'(wr_ready), 64'd1);
    push_run(8, 211, 1, 1'b1);
    chk("R10 full deasserts ready", 64'(wr_ready), 64'd0);
    wait_cyc(2);
    chk("R10 still full", 64'(wr_ready), 64'd0);
    pop_run("R10 first packet", 7, 0, 300, 1'b1);
    chk("R10 space freed", 64'(wr_ready), 64'd1);
    pop_run("R10 second packet", 8, 0, 212, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_thresh("R2 code01", 2'b01, 432);
    t_thresh("R3 code10", 2'b10, 256);
    t_thresh("R3 code11", 2'b11, 128);
    t_no_cut("R4 code00", 2'b00, 1'b1, 1'b1);
    t_short();
    t_no_cut("R8 retry off", 2'b11, 1'b1, 1'b0);
    t_no_cut("R9 enh off", 2'b11, 1'b0, 1'b1);
    t_underrun();
    t_full();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule